// File: doc/BRIEF.md
# Converter Task Scheduler

Three conversion tasks share one image-conversion datapath: pre-process encode (task 0), pre-process viewfinder (task 1) and post-process (task 2). Each task moves through a downsizing section, a main section and a rotation section, in that order. This scheduler decides which task, in which section, owns the datapath. It hands the datapath over only at a point that suits the section: after a burst of eight pixels in downsizing, at the end of a line in the main section, and at the end of a whole frame in rotation.

The datapath reports its progress with three strobes: one per pixel, one per line and one per frame. The scheduler is a four-state machine with the states IDLE, DOWNSIZE, MAIN and ROTATE. Its transitions are:
- IDLE to a busy state when some task requests.
- A busy state to IDLE at release when nothing is requested.
- A busy state to a busy state at release when some task requests, with no idle cycle between.
- A busy state to itself while its unit is still running.

The next owner is chosen round-robin. The search starts at the task after the one that released last.

Top module: `imgconv_sched`

## Requirements
- R1: Request bit `t*3+s` means task t wants section s (s=0 downsizing, s=1 main, s=2 rotation). When a task requests several sections, it is granted the lowest-numbered one.
- R2: `grant_task` and `grant_sec` are each one-hot0. Both are all-zero together when no task holds the grant.
- R3: In IDLE, any request produces a grant on the next clock edge.
- R4: The winner is the first requesting task found by searching upward from a pointer and wrapping. Reset sets the pointer to task 0.
- R5: A grant in downsizing is held for exactly `BURST_PIX` (8) `pix_done` pulses. `line_done` and `frame_done` do not release it.
- R6: A grant in the main section is released by `line_done`. `pix_done` and `frame_done` do not release it.
- R7: A grant in rotation is released by `frame_done`. `pix_done` and `line_done` do not release it.
- R8: A grant stays unchanged until its release strobe, even if the owner withdraws its request.
- R9: At release, arbitration happens on the same edge and the pointer becomes the released task plus one. If nothing is requested, the block returns to IDLE with all grants zero.
- R10: Strobes received in IDLE neither create a grant nor move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 9 | Per task and section request, bit t*3+s |
| pix_done | input | 1 | Datapath finished one pixel |
| line_done | input | 1 | Datapath finished one line |
| frame_done | input | 1 | Datapath finished one frame |
| grant_task | output | 3 | One-hot owner task |
| grant_sec | output | 3 | One-hot section of the owner |

## Verification
The assertions check on every cycle:
- the one-hot shape of the grant;
- that a grant holds until the strobe matching its section;
- that a downsizing grant survives until the eighth pixel, using a pixel counter kept in the checker;
- that IDLE responds to requests and stays put without them.

Only the bench's scenarios can show which task and section win. A sweep over every request pattern shows the lowest-section choice and the round-robin order as the pointer moves. It also covers back-to-back hand-over, a withdrawn request, and strobes that arrive in IDLE.

// File: rtl/imgconv_sched_pkg.sv
package imgconv_sched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DOWNSIZE = 2'd1,
        ST_MAIN     = 2'd2,
        ST_ROTATE   = 2'd3
    } sched_state_e;

    localparam int SEC_NUM   = 3;
    localparam int SEC_DS    = 0;
    localparam int SEC_MAIN  = 1;
    localparam int SEC_ROT   = 2;
endpackage

// File: rtl/imgconv_sec_pick.sv
// Picks the earliest section a task asks for (R1).
module imgconv_sec_pick (
    input  logic [2:0] sec_req,
    output logic       any,
    output logic [1:0] sec_idx
);
    always_comb begin
        any = |sec_req;
        if (sec_req[0])      sec_idx = 2'd0;
        else if (sec_req[1]) sec_idx = 2'd1;
        else                 sec_idx = 2'd2;
    end
endmodule

// File: rtl/imgconv_rr_pick.sv
// Round-robin search starting at a pointer (R4).
module imgconv_rr_pick #(
    parameter int NTASK = 3,
    localparam int IDXW = (NTASK > 1) ? $clog2(NTASK) : 1
) (
    input  logic [NTASK-1:0] task_req,
    input  logic [IDXW-1:0]  start,
    output logic             found,
    output logic [IDXW-1:0]  winner
);
    always_comb begin
        found  = 1'b0;
        winner = '0;
        for (int k = 0; k < NTASK; k++) begin
            int idx;
            idx = int'(start) + k;
            if (idx >= NTASK) idx = idx - NTASK;
            if (!found && task_req[idx]) begin
                found  = 1'b1;
                winner = IDXW'(idx);
            end
        end
    end
endmodule

// File: rtl/imgconv_burst_cnt.sv
// Counts pixels inside a downsizing burst (R5).
module imgconv_burst_cnt #(
    parameter int BURST_PIX = 8,
    localparam int CW = (BURST_PIX > 1) ? $clog2(BURST_PIX) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == CW'(BURST_PIX - 1));
endmodule

// File: rtl/imgconv_sched.sv
module imgconv_sched #(
    parameter int NTASK     = 3,
    parameter int BURST_PIX = 8,
    localparam int IDXW     = (NTASK > 1) ? $clog2(NTASK) : 1,
    localparam int REQW     = NTASK * imgconv_sched_pkg::SEC_NUM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REQW-1:0]  req,
    input  logic             pix_done,
    input  logic             line_done,
    input  logic             frame_done,
    output logic [NTASK-1:0] grant_task,
    output logic [2:0]       grant_sec
);
    import imgconv_sched_pkg::*;

    sched_state_e    state_q, state_d;
    logic [IDXW-1:0] owner_q, owner_d;
    logic [IDXW-1:0] ptr_q, ptr_d;

    logic [NTASK-1:0] task_any;
    logic [1:0]       task_sec [NTASK];

    // R1: per-task section choice
    for (genvar t = 0; t < NTASK; t++) begin : g_task
        imgconv_sec_pick u_sec (
            .sec_req (req[t*SEC_NUM +: SEC_NUM]),
            .any     (task_any[t]),
            .sec_idx (task_sec[t])
        );
    end

    logic [IDXW-1:0] owner_next;
    assign owner_next = (owner_q == IDXW'(NTASK - 1)) ? '0 : owner_q + 1'b1;

    logic [IDXW-1:0] search_start;
    logic            rr_found;
    logic [IDXW-1:0] rr_win;
    assign search_start = (state_q == ST_IDLE) ? ptr_q : owner_next;

    imgconv_rr_pick #(.NTASK(NTASK)) u_rr (
        .task_req (task_any),
        .start    (search_start),
        .found    (rr_found),
        .winner   (rr_win)
    );

    logic burst_last;
    logic release_now;
    logic arbitrate;

    imgconv_burst_cnt #(.BURST_PIX(BURST_PIX)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (arbitrate),
        .inc   (state_q == ST_DOWNSIZE && pix_done),
        .last  (burst_last)
    );

    // R5/R6/R7: section-specific release points
    always_comb begin
        unique case (state_q)
            ST_IDLE:     release_now = 1'b0;
            ST_DOWNSIZE: release_now = pix_done && burst_last;
            ST_MAIN:     release_now = line_done;
            ST_ROTATE:   release_now = frame_done;
            default:     release_now = 1'b0;
        endcase
        arbitrate = (state_q == ST_IDLE) || release_now;
    end

    // Next-state logic (R3, R8, R9, R10)
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        ptr_d   = ptr_q;
        if (release_now) ptr_d = owner_next;
        if (arbitrate) begin
            if (rr_found) begin
                owner_d = rr_win;
                unique case (task_sec[rr_win])
                    2'd0:    state_d = ST_DOWNSIZE;
                    2'd1:    state_d = ST_MAIN;
                    default: state_d = ST_ROTATE;
                endcase
            end else begin
                state_d = ST_IDLE;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            ptr_q   <= ptr_d;
        end
    end

    // Outputs (R2)
    always_comb begin
        grant_task = '0;
        grant_sec  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DOWNSIZE: begin
                grant_task[owner_q] = 1'b1;
                grant_sec[SEC_DS]   = 1'b1;
            end
            ST_MAIN: begin
                grant_task[owner_q] = 1'b1;
                grant_sec[SEC_MAIN] = 1'b1;
            end
            ST_ROTATE: begin
                grant_task[owner_q] = 1'b1;
                grant_sec[SEC_ROT]  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/imgconv_sched_chk.sv
module imgconv_sched_chk #(
    parameter int NTASK     = 3,
    parameter int BURST_PIX = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NTASK*3-1:0]     req,
    input logic                   pix_done,
    input logic                   line_done,
    input logic                   frame_done,
    input logic [NTASK-1:0]       grant_task,
    input logic [2:0]             grant_sec
);
    int chk_pix;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             chk_pix <= 0;
        else if (!grant_sec[0]) chk_pix <= 0;
        else if (pix_done)      chk_pix <= (chk_pix == BURST_PIX - 1) ? 0 : chk_pix + 1;
    end

    assert_grant_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_task) && $onehot0(grant_sec) && ((grant_task == '0) == (grant_sec == '0)));

    assert_hold_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_task && !pix_done && !line_done && !frame_done)
        |=> ($stable(grant_task) && $stable(grant_sec)));

    assert_burst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_sec[0] && !(pix_done && chk_pix == BURST_PIX - 1))
        |=> ($stable(grant_task) && $stable(grant_sec)));

    assert_line_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_sec[1] && !line_done) |=> ($stable(grant_task) && $stable(grant_sec)));

    assert_frame_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_sec[2] && !frame_done) |=> ($stable(grant_task) && $stable(grant_sec)));

    assert_idle_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_task == '0 && |req) |=> (|grant_task));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_task == '0 && req == '0) |=> (grant_task == '0));
endmodule

bind imgconv_sched imgconv_sched_chk #(.NTASK(NTASK), .BURST_PIX(BURST_PIX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .pix_done   (pix_done),
    .line_done  (line_done),
    .frame_done (frame_done),
    .grant_task (grant_task),
    .grant_sec  (grant_sec)
);

// File: tb/imgconv_sched_bench.sv
module imgconv_sched_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] req = '0;
    logic       pix_done = 1'b0, line_done = 1'b0, frame_done = 1'b0;
    logic [2:0] grant_task, grant_sec;

    int tests = 0, fails = 0;
    int ptr = 0;

    always #5 clk = ~clk;

    imgconv_sched u_imgconv_sched (
        .clk(clk), .rst_n(rst_n), .req(req),
        .pix_done(pix_done), .line_done(line_done), .frame_done(frame_done),
        .grant_task(grant_task), .grant_sec(grant_sec)
    );

    function automatic int sec_of(logic [8:0] r, int t);
        if (r[t*3])   return 0;
        if (r[t*3+1]) return 1;
        return 2;
    endfunction

    function automatic int pick(int p, logic [8:0] r);
        for (int k = 0; k < 3; k++) begin
            int t;
            t = (p + k) % 3;
            if (r[t*3 +: 3] != 3'b000) return t;
        end
        return -1;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        pix_done = 0; line_done = 0; frame_done = 0;
    endtask

    task automatic check(string tag, int et, int es);
        logic [2:0] xt, xs;
        xt = (et < 0) ? 3'b000 : (3'b001 << et);
        xs = (et < 0) ? 3'b000 : (3'b001 << es);
        tests++;
        if (grant_task !== xt || grant_sec !== xs) begin
            fails++;
            $display("FAIL %s: task=%b sec=%b expected task=%b sec=%b", tag, grant_task, grant_sec, xt, xs);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 reset state", -1, 0);
        rst_n = 1;
        step();

        // R10: strobes while idle
        pix_done = 1; line_done = 1; frame_done = 1;
        step();
        check("R10 strobes in idle", -1, 0);

        // R4: pointer at reset is task 0; R9 back-to-back rotation through tasks
        req = 9'b010_010_010;
        step();
        check("R4 reset pointer picks task 0", 0, 1);
        line_done = 1; step();
        check("R9 hand-over to task 1", 1, 1);
        line_done = 1; step();
        check("R9 hand-over to task 2", 2, 1);
        line_done = 1; step();
        check("R9 wrap to task 0", 0, 1);
        line_done = 1; req = '0; step();
        check("R9 idle after release", -1, 0);
        ptr = 1;

        // Sweep every request pattern
        for (int p = 1; p < 512; p++) begin
            int t, s;
            req = p[8:0];
            t = pick(ptr, req);
            s = sec_of(req, t);
            step();
            check("R1 R3 R4 sweep grant", t, s);
            if (s == 0) begin
                for (int i = 0; i < 7; i++) begin
                    pix_done = 1;
                    if (i == 3) begin line_done = 1; frame_done = 1; end
                    step();
                    check("R5 burst held", t, s);
                end
                pix_done = 1; req = '0; step();
                check("R5 R9 burst released", -1, 0);
            end else if (s == 1) begin
                pix_done = 1; frame_done = 1; req = '0; step();
                check("R6 R8 line held after request drop", t, s);
                line_done = 1; step();
                check("R6 R9 line released", -1, 0);
            end else begin
                pix_done = 1; line_done = 1; step();
                check("R7 frame held", t, s);
                frame_done = 1; req = '0; step();
                check("R7 R9 frame released", -1, 0);
            end
            ptr = (t + 1) % 3;
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule